// File: doc/BRIEF.md
# System Global Control Register File

This block is a bank of 32-bit control words reached through a plain single-cycle register bus inside a 4 KiB address window. A bus master presents a byte address, a write strobe and write data. The word at that address can be read at any time through a combinational read port. Each word follows one of four write rules: it is read-only, it stores the written value, it clears the bits written as one, or it sets the bits written as one.

A synchronous reset loads a fixed cold-start image. Two words take their reset value from input pins instead of constants: the strap snapshot word and the module-disable word. One more word carries a memory-size code that is worked out at elaboration from a log2 DRAM-size parameter. Accesses that are misaligned or fall beyond the last implemented word have no effect, and reads of them return zero.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the word at 0x000 reads 0x04A92750, 0x014 reads 0x0000FFFF, 0x038 reads 0x00000003, 0x03C reads 0x0000035E, 0x050 reads 0x0000004E, 0x060 reads 0x00080000 (bit 19 only), 0x06C reads 0x80000000, 0x078 reads 0x000000C0 and 0x098 reads 0x5A00F3CF. Every other implemented word, for example 0x008, reads zero.
- R2: During reset the word at 0x004 loads from `strap_word` and the word at 0x07C loads from `module_off_cfg`.
- R3: After reset the word at 0x09C reads 0x00001002 OR ((DRAM_LOG2 - 27) << 8). With the default DRAM_LOG2 of 30 this is 0x00001302. DRAM_LOG2 values outside 27..31 are rejected at elaboration.
- R4: Writes to 0x000, 0x004 and 0x040 leave those words unchanged.
- R5: A write to 0x06C or 0x0D4 leaves old AND NOT data.
- R6: A write to 0x070 or 0x07C leaves old OR data.
- R7: A write to any other implemented word stores all 32 data bits unchanged.
- R8: Byte addresses from 0x148 up to 0xFFC read zero. Writes to them change no implemented word.
- R9: An address with bits [1:0] not equal to zero reads zero, and a write to it changes no word.
- R10: Read data follows the addressed word combinationally. A write takes effect at the clock edge that samples the strobe, so before that edge the read still shows the old value and after it the read shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe, sampled at the rising edge |
| reg_addr | input | 12 | Byte address inside the 4 KiB window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data of the addressed word |
| strap_word | input | 32 | Reset value of the strap snapshot word at 0x004 |
| module_off_cfg | input | 32 | Reset value of the module-disable word at 0x07C |

## Verification
Read data has no latency: the bench moves the address on the falling edge and samples 1 ns later in the same cycle. A write is due one edge after the strobe. Each write task raises the strobe on a falling edge and drops it on the next falling edge, and only then reads the word back. For R10 the bench also samples while the strobe is still high, before the edge, to see that the old value is still held. The bound checker compares the read port one cycle after a write with the value held before the write and with the write data, for each write rule.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int NUM_WORDS = 82;                 // last word at 0x144
    localparam int SEL_W     = $clog2(NUM_WORDS);
    localparam int FIDX_W    = ADDR_W - 2;
    localparam int DRAM_MIN_LOG2 = 27;             // 128 MiB
    localparam int DRAM_MAX_LOG2 = 31;             // 2 GiB

    // word indices (byte offset / 4)
    localparam int IX_IDENT    = 0;
    localparam int IX_STRAPS   = 1;
    localparam int IX_PADEN    = 5;
    localparam int IX_SWSTRAP  = 14;
    localparam int IX_IRQCTL   = 15;
    localparam int IX_IRQSTAT  = 16;
    localparam int IX_HOSTIF   = 20;
    localparam int IX_IRQCTL2  = 24;
    localparam int IX_RSTCAUSE = 27;
    localparam int IX_LOCKSET  = 28;
    localparam int IX_DSCOUNT  = 30;
    localparam int IX_MODOFF   = 31;
    localparam int IX_VLEVEL   = 38;
    localparam int IX_MEMCFG   = 39;
    localparam int IX_BOOTSTAT = 53;

    typedef enum logic [1:0] {
        POL_RW  = 2'd0,
        POL_RO  = 2'd1,
        POL_W1C = 2'd2,
        POL_W1S = 2'd3
    } wr_policy_e;

    typedef enum logic [1:0] {
        RSRC_CONST = 2'd0,
        RSRC_STRAP = 2'd1,
        RSRC_CFG   = 2'd2
    } rst_src_e;

    typedef struct packed {
        logic              hit;   // aligned and inside the array
        logic              wr;    // write strobe qualified by hit
        logic [SEL_W-1:0]  idx;
        logic [WORD_W-1:0] data;
    } bus_req_t;

    function automatic wr_policy_e policy_of(int idx);
        case (idx)
            IX_IDENT, IX_STRAPS, IX_IRQSTAT: return POL_RO;
            IX_RSTCAUSE, IX_BOOTSTAT:        return POL_W1C;
            IX_LOCKSET, IX_MODOFF:           return POL_W1S;
            default:                         return POL_RW;
        endcase
    endfunction

    function automatic rst_src_e rst_src_of(int idx);
        case (idx)
            IX_STRAPS: return RSRC_STRAP;
            IX_MODOFF: return RSRC_CFG;
            default:   return RSRC_CONST;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] mem_code(int dram_log2);
        logic [WORD_W-1:0] code;
        code = WORD_W'(dram_log2 - DRAM_MIN_LOG2);
        return 32'h0000_1002 | (code << 8);
    endfunction

    function automatic logic [WORD_W-1:0] cold_value(int idx, int dram_log2);
        case (idx)
            IX_IDENT:    return 32'h04A9_2750;
            IX_PADEN:    return 32'h0000_FFFF;
            IX_SWSTRAP:  return 32'h0000_0003;
            IX_IRQCTL:   return 32'h0000_035E;
            IX_HOSTIF:   return 32'h0000_004E;
            IX_IRQCTL2:  return 32'h0008_0000;
            IX_RSTCAUSE: return 32'h8000_0000;
            IX_DSCOUNT:  return 32'h0000_00C0;
            IX_VLEVEL:   return 32'h5A00_F3CF;
            IX_MEMCFG:   return mem_code(dram_log2);
            default:     return '0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output bus_req_t          req
);
    logic [FIDX_W-1:0] full_idx;
    logic              aligned;
    logic              in_range;

    always_comb begin
        full_idx = addr[ADDR_W-1:2];
        aligned  = (addr[1:0] == 2'b00);
        in_range = (full_idx < FIDX_W'(NUM_WORDS));
        req.hit  = aligned && in_range;
        req.wr   = wr_en && aligned && in_range;
        req.idx  = full_idx[SEL_W-1:0];
        req.data = wdata;
    end
endmodule

// File: rtl/sysctl_word.sv
module sysctl_word
    import sysctl_pkg::*;
#(
    parameter wr_policy_e POLICY = POL_RW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rst_val,
    input  logic              wr_hit,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q
);
    logic [WORD_W-1:0] nxt;

    generate
        if (POLICY == POL_RO) begin : g_ro
            logic unused_ro;
            assign unused_ro = wr_hit ^ (^wdata);
            assign nxt = q;
        end else if (POLICY == POL_W1C) begin : g_w1c
            assign nxt = wr_hit ? (q & ~wdata) : q;
        end else if (POLICY == POL_W1S) begin : g_w1s
            assign nxt = wr_hit ? (q | wdata) : q;
        end else begin : g_rw
            assign nxt = wr_hit ? wdata : q;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= rst_val;
        else     q <= nxt;
    end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
    import sysctl_pkg::*;
(
    input  bus_req_t          req,
    input  logic [WORD_W-1:0] words [NUM_WORDS],
    output logic [WORD_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (req.hit) rdata = words[req.idx];
    end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter logic [4:0] DRAM_LOG2 = 5'd30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic [WORD_W-1:0] strap_word,
    input  logic [WORD_W-1:0] module_off_cfg
);
    localparam int DRAM_L2 = int'(DRAM_LOG2);

    generate
        if (DRAM_L2 < DRAM_MIN_LOG2 || DRAM_L2 > DRAM_MAX_LOG2) begin : g_bad_dram
            $error("sysctl_regfile: DRAM_LOG2 must lie in 27..31");
        end
    endgenerate

    bus_req_t          req;
    logic [WORD_W-1:0] words [NUM_WORDS];

    sysctl_decode u_decode (
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .req   (req)
    );

    generate
        for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
            logic [WORD_W-1:0] rv;
            logic              hit_i;

            if (rst_src_of(i) == RSRC_STRAP) begin : g_rs
                assign rv = strap_word;
            end else if (rst_src_of(i) == RSRC_CFG) begin : g_rc
                assign rv = module_off_cfg;
            end else begin : g_rk
                assign rv = cold_value(i, DRAM_L2);
            end

            assign hit_i = req.wr && (req.idx == SEL_W'(i));

            sysctl_word #(.POLICY(policy_of(i))) u_word (
                .clk     (clk),
                .rst     (rst),
                .rst_val (rv),
                .wr_hit  (hit_i),
                .wdata   (req.data),
                .q       (words[i])
            );
        end
    endgenerate

    sysctl_rdmux u_rdmux (
        .req   (req),
        .words (words),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
    import sysctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0] reg_wdata,
    input logic [WORD_W-1:0] reg_rdata
);
    logic       wr_ok;
    wr_policy_e pol;

    always_comb begin
        wr_ok = reg_wr && (reg_addr[1:0] == 2'b00) && (reg_addr < 12'h148);
        pol   = policy_of(int'(reg_addr[ADDR_W-1:2]));
    end

    // R1
    ident_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && reg_addr == 12'h000) |-> reg_rdata == 32'h04A9_2750);

    // R4
    ro_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && pol == POL_RO) |=>
        (reg_addr == $past(reg_addr)) -> (reg_rdata == $past(reg_rdata)));

    // R5
    w1c_result_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && pol == POL_W1C) |=>
        (reg_addr == $past(reg_addr)) -> (reg_rdata == ($past(reg_rdata) & ~$past(reg_wdata))));

    // R6
    w1s_result_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && pol == POL_W1S) |=>
        (reg_addr == $past(reg_addr)) -> (reg_rdata == ($past(reg_rdata) | $past(reg_wdata))));

    // R7
    rw_store_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && pol == POL_RW) |=>
        (reg_addr == $past(reg_addr)) -> (reg_rdata == $past(reg_wdata)));

    // R8
    oor_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr >= 12'h148) |-> reg_rdata == '0);

    // R9
    misalign_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[1:0] != 2'b00) |-> reg_rdata == '0);
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata)
);

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;
    localparam logic [4:0] DLOG2 = 5'd30;
    localparam logic [31:0] STRAP = 32'hA5A5_0F0F;
    localparam logic [31:0] MCFG  = 32'h0000_1234;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] strap_word = STRAP;
    logic [31:0] module_off_cfg = MCFG;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    sysctl_regfile #(.DRAM_LOG2(DLOG2)) u_sysctl_regfile (
        .clk            (clk),
        .rst            (rst),
        .reg_wr         (reg_wr),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .strap_word     (strap_word),
        .module_off_cfg (module_off_cfg)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset_image;
        logic [31:0] v;
        rd(12'h000, v); check("R1 ident",      v, 32'h04A9_2750);
        rd(12'h014, v); check("R1 0x014",      v, 32'h0000_FFFF);
        rd(12'h038, v); check("R1 0x038",      v, 32'h0000_0003);
        rd(12'h03C, v); check("R1 0x03C",      v, 32'h0000_035E);
        rd(12'h050, v); check("R1 0x050",      v, 32'h0000_004E);
        rd(12'h060, v); check("R1 0x060",      v, 32'h0008_0000);
        rd(12'h06C, v); check("R1 0x06C",      v, 32'h8000_0000);
        rd(12'h078, v); check("R1 0x078",      v, 32'h0000_00C0);
        rd(12'h098, v); check("R1 0x098",      v, 32'h5A00_F3CF);
        rd(12'h008, v); check("R1 zero 0x008", v, 32'h0);
        rd(12'h144, v); check("R1 zero 0x144", v, 32'h0);
    endtask

    task automatic t_straps;
        logic [31:0] v;
        rd(12'h004, v); check("R2 strap", v, STRAP);
        rd(12'h07C, v); check("R2 cfg",   v, MCFG);
    endtask

    task automatic t_dram;
        logic [31:0] v;
        rd(12'h09C, v);
        check("R3 memcode", v, 32'h0000_1002 | ((32'(DLOG2) - 32'd27) << 8));
    endtask

    task automatic t_readonly;
        logic [31:0] v;
        wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, v); check("R4 ident",  v, 32'h04A9_2750);
        wr(12'h004, 32'h0);         rd(12'h004, v); check("R4 strap",  v, STRAP);
        wr(12'h040, 32'hDEAD_BEEF); rd(12'h040, v); check("R4 status", v, 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(12'h06C, 32'h0000_0001); rd(12'h06C, v); check("R5 no-clear", v, 32'h8000_0000);
        wr(12'h06C, 32'h8000_0000); rd(12'h06C, v); check("R5 clear",    v, 32'h0);
        wr(12'h0D4, 32'hFFFF_FFFF); rd(12'h0D4, v); check("R5 0x0D4",    v, 32'h0);
    endtask

    task automatic t_w1s;
        logic [31:0] v;
        wr(12'h070, 32'h0000_0003);
        wr(12'h070, 32'h0000_0008); rd(12'h070, v); check("R6 lock",   v, 32'h0000_000B);
        wr(12'h07C, 32'h0001_0000); rd(12'h07C, v); check("R6 modoff", v, 32'h0001_1234);
        wr(12'h07C, 32'h0);         rd(12'h07C, v); check("R6 zero",   v, 32'h0001_1234);
    endtask

    task automatic t_rw;
        logic [31:0] v;
        wr(12'h008, 32'h1234_5678); rd(12'h008, v); check("R7 0x008", v, 32'h1234_5678);
        wr(12'h03C, 32'h0);         rd(12'h03C, v); check("R7 0x03C", v, 32'h0);
        wr(12'h144, 32'hCAFE_F00D); rd(12'h144, v); check("R7 0x144", v, 32'hCAFE_F00D);
    endtask

    task automatic t_out_of_range;
        logic [31:0] v;
        wr(12'h148, 32'hFFFF_FFFF); rd(12'h148, v); check("R8 0x148 rd", v, 32'h0);
        wr(12'h208, 32'hAAAA_AAAA); rd(12'h208, v); check("R8 0x208 rd", v, 32'h0);
        rd(12'h008, v); check("R8 0x008 kept", v, 32'h1234_5678);
        rd(12'h144, v); check("R8 0x144 kept", v, 32'hCAFE_F00D);
        rd(12'h000, v); check("R8 ident kept", v, 32'h04A9_2750);
        rd(12'hFFC, v); check("R8 0xFFC rd",   v, 32'h0);
    endtask

    task automatic t_misaligned;
        logic [31:0] v;
        rd(12'h001, v); check("R9 rd 0x001", v, 32'h0);
        wr(12'h00A, 32'h0); rd(12'h008, v); check("R9 0x008 kept", v, 32'h1234_5678);
        wr(12'h00B, 32'h0); rd(12'h00B, v); check("R9 rd 0x00B",   v, 32'h0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h00C; reg_wdata = 32'h5555_AAAA;
        #1; check("R10 before edge", reg_rdata, 32'h0);
        @(posedge clk); #1;
        check("R10 after edge", reg_rdata, 32'h5555_AAAA);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_image();
        t_straps();
        t_dram();
        t_readonly();
        t_w1c();
        t_w1s();
        t_rw();
        t_out_of_range();
        t_misaligned();
        t_timing();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule